// File: doc/BRIEF.md
# Eight-Function Arithmetic/Logic Unit

This block is the combinational arithmetic and logic stage of a small 16-bit load/store processor. A 3-bit function code selects one of eight operations on two operands. The operations are modular add and subtract, one's-complement inversion, logical shifts in both directions by an amount held in a register, bitwise AND and OR, and a signed set-on-less-than that yields 0 or 1.

Alongside the result, the unit drives a zero flag. The processor's branch logic reads this flag after a subtraction to decide equality branches.

No register sits on the path, so the result is valid in the same cycle that the operands and the function code are presented. The unit has no carry or overflow flags and no arithmetic right shift.

Top module: `alu8f`

## Requirements
- R1: With `func` = 000 the result is `opa + opb` modulo 2^16.
- R2: With `func` = 001 the result is `opa - opb` modulo 2^16.
- R3: With `func` = 010 the result is the bitwise complement of `opa`, and `opb` has no effect on it.
- R4: With `func` = 011 the result is `opa` shifted left by the shift amount, with zeros entering at bit 0.
- R5: With `func` = 100 the result is `opa` shifted right by the shift amount, with zeros entering at bit 15.
- R6: The shift amount is `opb[4:0]`, and bits 15:5 of `opb` are ignored. An amount of 16 to 31 gives a result of zero for both shifts.
- R7: With `func` = 101 the result is `opa & opb`. With `func` = 110 it is `opa | opb`.
- R8: With `func` = 111 the result is 1 when `opa` is less than `opb` as signed two's-complement numbers, and 0 otherwise. Bits 15:1 are always zero.
- R9: `zero` is 1 exactly when the 16-bit result is all zeros, for every function.
- R10: The outputs are purely combinational. They reflect the inputs within the same clock cycle, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func | input | 3 | Function select (encoding given in R1 to R8) |
| opa | input | 16 | First operand; the value shifted or inverted |
| opb | input | 16 | Second operand; supplies the shift amount for shifts |
| result | output | 16 | Operation result |
| zero | output | 1 | High when `result` is zero |

## Verification
The bench builds the unit with its default width of 16, so the shift-amount field is 5 bits wide. Amounts 16 to 31 are therefore legal inputs, and the saturating-to-zero case of R6 is reached directly, including amounts whose upper `opb` bits are set. At this width, signed corners can be listed by hand: the most negative value, the most positive value, equal operands, and operands whose signed and unsigned orders disagree. Random operands then fill in between these corners for each function code.

// File: rtl/alu8f.sv
module alu8f #(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       func,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int AMT_W = $clog2(WIDTH) + 1;

  localparam logic [2:0] F_ADD = 3'd0;
  localparam logic [2:0] F_SUB = 3'd1;
  localparam logic [2:0] F_INV = 3'd2;
  localparam logic [2:0] F_SHL = 3'd3;
  localparam logic [2:0] F_SHR = 3'd4;
  localparam logic [2:0] F_AND = 3'd5;
  localparam logic [2:0] F_OR  = 3'd6;
  localparam logic [2:0] F_SLT = 3'd7;

  logic [AMT_W-1:0] amt;
  logic             too_far;
  logic             less;

  assign amt     = opb[AMT_W-1:0];
  assign too_far = amt >= AMT_W'(WIDTH);
  assign less    = $signed(opa) < $signed(opb);

  always_comb begin
    case (func)
      F_ADD:   result = opa + opb;
      F_SUB:   result = opa - opb;
      F_INV:   result = ~opa;
      F_SHL:   result = too_far ? '0 : opa << amt;
      F_SHR:   result = too_far ? '0 : opa >> amt;
      F_AND:   result = opa & opb;
      F_OR:    result = opa | opb;
      F_SLT:   result = {{(WIDTH-1){1'b0}}, less};
      default: result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/alu8f_chk.sv
module alu8f_chk #(
  parameter int WIDTH = 16
) (
  input logic [2:0]       func,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [WIDTH-1:0] result,
  input logic             zero
);
  localparam int AMT_W = $clog2(WIDTH) + 1;

  always_comb begin
    if (func == 3'd1)
      AST_SUB_INVERTS_ADD: assert (WIDTH'(result + opb) == opa) else $error("sub inverse"); // R2
    if (func == 3'd2)
      AST_INV_ALL_FLIPPED: assert ((result ^ opa) == {WIDTH{1'b1}}) else $error("inv"); // R3
    if ((func == 3'd3 || func == 3'd4) && opb[AMT_W-1])
      AST_LONG_SHIFT_EMPTY: assert (result == '0) else $error("long shift"); // R6
    if (func == 3'd5)
      AST_AND_WITHIN_A: assert ((result & ~opa) == '0) else $error("and"); // R7
    if (func == 3'd6)
      AST_OR_COVERS_A: assert ((result & opa) == opa) else $error("or"); // R7
    if (func == 3'd7)
      AST_SLT_ONE_BIT: assert (result[WIDTH-1:1] == '0) else $error("slt width"); // R8
    if (zero)
      AST_ZERO_MEANS_EMPTY: assert (result == '0) else $error("zero set"); // R9
    else
      AST_NONZERO_MEANS_BITS: assert (result != '0) else $error("zero clear"); // R9
  end
endmodule

bind alu8f alu8f_chk #(.WIDTH(WIDTH)) u_chk (
  .func(func), .opa(opa), .opb(opb), .result(result), .zero(zero)
);

// File: tb/alu8f_tb.sv
module alu8f_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  func = 3'd0;
  logic [15:0] opa = 16'd0;
  logic [15:0] opb = 16'd0;
  logic [15:0] result;
  logic        zero;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alu8f u_dut (.func(func), .opa(opa), .opb(opb), .result(result), .zero(zero));

  function automatic int model(int f, int x, int y);
    int amt, sx, sy;
    amt = y % 32;
    sx = (x >= 32768) ? x - 65536 : x;
    sy = (y >= 32768) ? y - 65536 : y;
    case (f)
      0: return (x + y) % 65536;
      1: return (x - y + 65536) % 65536;
      2: return 65535 - x;
      3: return (amt >= 16) ? 0 : (x * (1 << amt)) % 65536;
      4: return (amt >= 16) ? 0 : x / (1 << amt);
      5: return x & y;
      6: return x | y;
      default: return (sx < sy) ? 1 : 0;
    endcase
  endfunction

  function automatic string tag_of(int f, int y);
    case (f)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return ((y % 32) >= 16) ? "R6" : "R4";
      4: return ((y % 32) >= 16) ? "R6" : "R5";
      5, 6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check_now(string tag, int f, int x, int y);
    int exp_r;
    exp_r = model(f, x, y);
    checks++;
    if (int'(result) != exp_r) begin
      failures++;
      $display("FAIL %s func=%0d a=%h b=%h result actual=%h expected=%h", tag, f, x, y, result, exp_r[15:0]);
    end
    checks++;
    if (zero != (exp_r == 0)) begin
      failures++;
      $display("FAIL R9 func=%0d a=%h b=%h zero actual=%0b expected=%0b", f, x, y, zero, exp_r == 0);
    end
  endtask

  // R10: inputs change at a rising edge and are checked at the next falling edge
  task automatic apply(int f, int x, int y);
    @(posedge clk);
    func <= 3'(f);
    opa  <= 16'(x);
    opb  <= 16'(y);
    @(negedge clk);
    check_now(tag_of(f, y), f, x, y);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    check_now("R10", 0, 0, 0);

    apply(0, 16'hFFFF, 16'h0001);
    apply(0, 16'h1234, 16'h4321);
    apply(1, 16'h0000, 16'h0001);
    apply(1, 16'h5555, 16'h5555);
    apply(2, 16'h0F0F, 16'h0000); // R3 b ignored
    apply(2, 16'h0F0F, 16'hFFFF); // R3 b ignored
    apply(2, 16'hFFFF, 16'h1234);
    apply(3, 16'h8001, 16'h0001);
    apply(3, 16'h0001, 16'h000F);
    apply(4, 16'h8001, 16'h000F);
    apply(4, 16'hFFFF, 16'h0004);
    apply(3, 16'hFFFF, 16'h0010); // R6
    apply(4, 16'hFFFF, 16'h001F); // R6
    apply(3, 16'h00F0, 16'hFFE1); // R6 high bits ignored, shift by 1
    apply(4, 16'h00F0, 16'h0024); // R6 high bits ignored, shift by 4
    apply(5, 16'hF0F0, 16'h0FF0);
    apply(6, 16'hF000, 16'h000F);
    apply(5, 16'h00FF, 16'hFF00);
    apply(7, 16'h8000, 16'h7FFF); // R8 signed: negative < positive
    apply(7, 16'h7FFF, 16'h8000);
    apply(7, 16'h1234, 16'h1234);
    apply(7, 16'hFFFF, 16'h0000);
    apply(7, 16'hFFFE, 16'hFFFF);

    for (int f = 0; f < 8; f++) begin
      for (int n = 0; n < 300; n++) begin
        int x, y;
        x = int'($urandom_range(0, 65535));
        y = (n % 4 == 0) ? int'($urandom_range(0, 40)) : int'($urandom_range(0, 65535));
        if (n % 10 == 0) y = x;
        apply(f, x, y);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule